// File: doc/BRIEF.md
# Multi-Line Continuous Read Sequencer

This block is the slave-side engine of a serial flash that serves the two fast read commands which move address and data over several IO lines at once. Working from a system clock, it samples the serial clock and an active-low select, counts serial clocks inside each select frame, and collects the opcode, the address and a mode byte. The dual command moves two bits per serial clock and the quad command moves four. After the mode byte and any dummy clocks, it fetches bytes through a combinational byte read port and drives them MSB first on the IO lines. The read address advances by one after each byte for as long as the serial clock keeps running.

The mode byte controls the next frame. If its upper nibble is 1010, the sequencer enters a state with no opcode: the frames that follow start directly with the address, in the width of the command that set the state. A frame that shifts all ones on the active lines through the address and mode positions leaves that state and returns no data. A read is refused while the external busy flag is set. The quad command is refused while the quad-enable input is low. A refused frame leaves the IO lines released until the select rises.

The serial clock must be at most a fifth of the system clock, because the serial clock, the select and the IO inputs pass through a two-stage synchronizer.

Top module: `qio_read_seq`

## Requirements
- R1: Opcode BBh, shifted in on IO0 over 8 rising edges, starts a dual frame. The dual frame has 12 address clocks and then 4 mode clocks, with IO1 carrying the more significant bit of each pair. Data starts on the first falling edge after the last mode clock, with no dummy clocks, on IO1/IO0 with io_oe = 0011.
- R2: Opcode EBh starts a quad frame. The quad frame has 6 address clocks and then 2 mode clocks, with IO3 carrying the most significant bit of each nibble, followed by exactly 4 dummy clocks. Data is driven on IO3..IO0 with io_oe = 1111.
- R3: A quad frame while qe is 0 returns no data, and the IO lines stay released for the rest of the frame.
- R4: A read whose mode byte completes while busy is 1 returns no data, and the IO lines stay released.
- R5: Each byte leaves MSB first. The address increments after every byte and wraps from FFFFFFh to 000000h.
- R6: io_oe is 0 during the opcode, address, mode and dummy clocks and whenever the select is high. It becomes nonzero only after a serial-clock falling edge.
- R7: A mode byte with upper nibble Ah (lower nibble ignored) makes the next frame start directly with the address, in the same width. This holds across frames for as long as each frame repeats Ah.
- R8: A mode byte with any other upper nibble makes the next frame start with an opcode again.
- R9: In the opcode-less state, a frame that presents all ones through the address and mode positions leaves the state and returns no data. That is 8 clocks of 1111 in quad, or 16 clocks of 11 in dual.
- R10: Reset releases the IO lines and clears the opcode-less state.
- R11: Any opcode other than BBh or EBh makes the frame return no data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low frame select |
| io_in | input | 4 | Sampled IO line values |
| io_out | output | 4 | Driven IO line values |
| io_oe | output | 4 | Per-line output enable |
| qe | input | 1 | Quad enable; quad frames are refused while it is low |
| busy | input | 1 | Program or erase in progress; reads are refused while it is high |
| mem_addr | output | ADDR_W | Byte address to the memory array |
| mem_data | input | 8 | Byte read combinationally at mem_addr |

## Verification
The hardest state to reach from the ports is the opcode-less state. It cannot be observed directly: it only changes how the next frame's first clocks are decoded. The stimulus first sets the state with an Ah mode byte, then sends a frame with no opcode and checks that the correct data comes back. It then clears the state, either with a mode byte other than Ah, with the all-ones frame or with reset. In each case a following frame shows which decoding is active. An opcode-less frame must be refused, and a frame that starts with a real opcode must return the bytes at its own address. If the address shifter had taken the opcode bits, the bytes would come from a different address.

// File: rtl/qrd_pkg.sv
package qrd_pkg;

  localparam logic [7:0] OPC_DUAL_IO = 8'hBB;
  localparam logic [7:0] OPC_QUAD_IO = 8'hEB;
  localparam logic [3:0] KEEP_NIB    = 4'hA;

  typedef enum logic [2:0] {
    PH_OPC, PH_ADDR, PH_MODE, PH_DUMMY, PH_DATA, PH_IGN
  } phase_t;

  // Lane value for one output slot of a byte. Quad uses slots 0..1 (upper
  // nibble first); dual uses slots 0..3 on the two low lanes, MSB pair first.
  function automatic logic [3:0] lane_slice(input logic [7:0] b,
                                            input logic [1:0] slot,
                                            input logic       quad);
    if (quad) return slot[0] ? b[3:0] : b[7:4];
    case (slot)
      2'd0:    return {2'b00, b[7:6]};
      2'd1:    return {2'b00, b[5:4]};
      2'd2:    return {2'b00, b[3:2]};
      default: return {2'b00, b[1:0]};
    endcase
  endfunction

  // Number of serial clocks that carry a field of 'bits' bits.
  function automatic int field_clks(input int bits, input logic quad);
    return quad ? bits / 4 : bits / 2;
  endfunction

endpackage

// File: rtl/qrd_edge_sync.sv
module qrd_edge_sync (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       cs_n,
  input  logic [3:0] io_in,
  output logic [3:0] io_s,
  output logic       sclk_rise,
  output logic       sclk_fall,
  output logic       frame_act
);
  logic [2:0] sclk_sh;
  logic [1:0] cs_sh;
  logic [3:0] io_s1, io_s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sh <= '0;
      cs_sh   <= 2'b11;
      io_s1   <= '0;
      io_s2   <= '0;
    end else begin
      sclk_sh <= {sclk_sh[1:0], sclk};
      cs_sh   <= {cs_sh[0], cs_n};
      io_s1   <= io_in;
      io_s2   <= io_s1;
    end
  end

  assign sclk_rise = sclk_sh[1] & ~sclk_sh[2];
  assign sclk_fall = ~sclk_sh[1] & sclk_sh[2];
  assign frame_act = ~cs_sh[1];
  assign io_s      = io_s2;
endmodule

// File: rtl/qrd_frame_ctrl.sv
module qrd_frame_ctrl
  import qrd_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int QUAD_DUMMY = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_act,
  input  logic              sclk_rise,
  input  logic [3:0]        io_s,
  input  logic              qe,
  input  logic              busy,
  output phase_t            phase,
  output logic              frame_quad,
  output logic [ADDR_W-1:0] start_addr,
  output logic              mode_done,
  output logic              reset_pat,
  output logic              data_start,
  output logic              cont
);
  localparam int ACLK_Q = ADDR_W / 4;
  localparam int ACLK_D = ADDR_W / 2;
  localparam int CNT_W  = $clog2(ACLK_D + QUAD_DUMMY + 9);

  phase_t            phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              quad_q, skip_q, cont_q, cont_quad_q;
  logic [6:0]        op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [5:0]        mode_q;

  logic [7:0]        op_nxt, mode_nxt;
  logic [ADDR_W-1:0] addr_nxt;
  logic              op_last, addr_last, mode_last, dummy_last, accept, step;

  assign step       = frame_act & sclk_rise;
  assign op_nxt     = {op_q, io_s[0]};
  assign addr_nxt   = quad_q ? {addr_q[ADDR_W-5:0], io_s} : {addr_q[ADDR_W-3:0], io_s[1:0]};
  assign mode_nxt   = quad_q ? {mode_q[3:0], io_s} : {mode_q, io_s[1:0]};
  assign op_last    = cnt_q == CNT_W'(7);
  assign addr_last  = cnt_q == CNT_W'(quad_q ? ACLK_Q - 1 : ACLK_D - 1);
  assign mode_last  = cnt_q == CNT_W'(field_clks(8, quad_q) - 1);
  assign dummy_last = cnt_q == CNT_W'(QUAD_DUMMY - 1);
  assign accept     = ~busy & (~quad_q | qe);

  assign mode_done  = step & (phase_q == PH_MODE) & mode_last;
  assign reset_pat  = mode_done & skip_q & (&addr_q) & (&mode_nxt);
  assign data_start = (mode_done & accept & ~reset_pat & ~quad_q) |
                      (step & (phase_q == PH_DUMMY) & dummy_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= PH_OPC;
      cnt_q       <= '0;
      quad_q      <= 1'b0;
      skip_q      <= 1'b0;
      cont_q      <= 1'b0;
      cont_quad_q <= 1'b0;
      op_q        <= '0;
      addr_q      <= '0;
      mode_q      <= '0;
    end else if (!frame_act) begin
      phase_q <= cont_q ? PH_ADDR : PH_OPC;
      cnt_q   <= '0;
      quad_q  <= cont_quad_q;
      skip_q  <= cont_q;
    end else if (sclk_rise) begin
      case (phase_q)
        PH_OPC: begin
          op_q  <= op_nxt[6:0];
          cnt_q <= cnt_q + 1'b1;
          if (op_last) begin
            cnt_q <= '0;
            if (op_nxt == OPC_DUAL_IO) begin
              quad_q  <= 1'b0;
              phase_q <= PH_ADDR;
            end else if (op_nxt == OPC_QUAD_IO) begin
              quad_q  <= 1'b1;
              phase_q <= PH_ADDR;
            end else begin
              phase_q <= PH_IGN;
            end
          end
        end
        PH_ADDR: begin
          addr_q <= addr_nxt;
          cnt_q  <= cnt_q + 1'b1;
          if (addr_last) begin
            cnt_q   <= '0;
            phase_q <= PH_MODE;
          end
        end
        PH_MODE: begin
          mode_q <= mode_nxt[5:0];
          cnt_q  <= cnt_q + 1'b1;
          if (mode_last) begin
            cnt_q <= '0;
            if (reset_pat) begin
              cont_q  <= 1'b0;
              phase_q <= PH_IGN;
            end else if (accept) begin
              cont_q      <= (mode_nxt[7:4] == KEEP_NIB);
              cont_quad_q <= quad_q;
              phase_q     <= quad_q ? PH_DUMMY : PH_DATA;
            end else begin
              phase_q <= PH_IGN;
            end
          end
        end
        PH_DUMMY: begin
          cnt_q <= cnt_q + 1'b1;
          if (dummy_last) begin
            cnt_q   <= '0;
            phase_q <= PH_DATA;
          end
        end
        default: ;
      endcase
    end
  end

  assign phase      = phase_q;
  assign frame_quad = quad_q;
  assign start_addr = addr_q;
  assign cont       = cont_q;
endmodule

// File: rtl/qrd_data_lanes.sv
module qrd_data_lanes
  import qrd_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_act,
  input  logic              sclk_fall,
  input  logic              in_data,
  input  logic              frame_quad,
  input  logic              data_start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [7:0]        mem_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [3:0]        io_out,
  output logic [3:0]        io_oe,
  output logic              byte_done
);
  logic [ADDR_W-1:0] rd_addr;
  logic [1:0]        slot;
  logic [3:0]        out_q, oe_q;
  logic              last_slot;

  assign last_slot = frame_quad ? (slot == 2'd1) : (slot == 2'd3);
  assign byte_done = frame_act & sclk_fall & in_data & last_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_addr <= '0;
      slot    <= '0;
      out_q   <= '0;
      oe_q    <= '0;
    end else if (!frame_act) begin
      slot  <= '0;
      out_q <= '0;
      oe_q  <= '0;
    end else if (data_start) begin
      rd_addr <= start_addr;
      slot    <= '0;
    end else if (sclk_fall && in_data) begin
      out_q <= lane_slice(mem_data, slot, frame_quad);
      oe_q  <= frame_quad ? 4'hF : 4'h3;
      if (last_slot) begin
        slot    <= '0;
        rd_addr <= rd_addr + 1'b1;
      end else begin
        slot <= slot + 1'b1;
      end
    end
  end

  assign mem_addr = rd_addr;
  assign io_out   = out_q;
  assign io_oe    = oe_q;
endmodule

// File: rtl/qio_read_seq.sv
module qio_read_seq
  import qrd_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int QUAD_DUMMY = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic [3:0]        io_in,
  output logic [3:0]        io_out,
  output logic [3:0]        io_oe,
  input  logic              qe,
  input  logic              busy,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_data
);
  logic [3:0]        io_s;
  logic              sclk_rise, sclk_fall, frame_act;
  phase_t            phase;
  logic              frame_quad, mode_done, reset_pat, data_start, cont;
  logic              in_data, byte_done;
  logic [ADDR_W-1:0] start_addr;

  qrd_edge_sync u_sync (
    .clk, .rst_n, .sclk, .cs_n, .io_in,
    .io_s, .sclk_rise, .sclk_fall, .frame_act
  );

  qrd_frame_ctrl #(.ADDR_W(ADDR_W), .QUAD_DUMMY(QUAD_DUMMY)) u_ctrl (
    .clk, .rst_n, .frame_act, .sclk_rise, .io_s, .qe, .busy,
    .phase, .frame_quad, .start_addr, .mode_done, .reset_pat,
    .data_start, .cont
  );

  assign in_data = (phase == PH_DATA);

  qrd_data_lanes #(.ADDR_W(ADDR_W)) u_lanes (
    .clk, .rst_n, .frame_act, .sclk_fall, .in_data, .frame_quad,
    .data_start, .start_addr, .mem_data,
    .mem_addr, .io_out, .io_oe, .byte_done
  );
endmodule

// File: rtl/qio_read_seq_chk.sv
module qio_read_seq_chk
  import qrd_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              qe,
  input logic              busy,
  input logic [3:0]        io_oe,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              sclk_fall,
  input logic              frame_act,
  input phase_t            phase,
  input logic              frame_quad,
  input logic              mode_done,
  input logic              reset_pat,
  input logic              cont,
  input logic              byte_done
);
  // R6: lines released once the select is high
  p_oe_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_act |=> io_oe == 4'h0);

  // R6: output enable only appears after a serial falling edge
  p_oe_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(io_oe != 4'h0) |-> $past(sclk_fall));

  // R1 and R2: enabled lanes match the width of the frame
  p_lane_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_act && io_oe != 4'h0) |-> (frame_quad ? io_oe == 4'hF : io_oe == 4'h3));

  // R3: quad frame refused without quad enable
  p_qe_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_done && frame_quad && !qe && !reset_pat) |=> phase == PH_IGN);

  // R4: read refused while busy
  p_busy_ign_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_done && busy && !reset_pat) |=> phase == PH_IGN);

  // R5: address advances by one per finished byte
  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> mem_addr == ADDR_W'($past(mem_addr) + 1'b1));

  // R7: opcode-less state is entered only at a mode byte
  p_cont_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cont) |-> $past(mode_done));

  // R9: all-ones frame leaves the opcode-less state
  p_reset_pat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reset_pat |=> !cont);
endmodule

bind qio_read_seq qio_read_seq_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .qe(qe), .busy(busy), .io_oe(io_oe),
  .mem_addr(mem_addr), .sclk_fall(sclk_fall), .frame_act(frame_act),
  .phase(phase), .frame_quad(frame_quad), .mode_done(mode_done),
  .reset_pat(reset_pat), .cont(cont), .byte_done(byte_done)
);

// File: tb/test_qio_read_seq.sv
`timescale 1ns/100ps
module test_qio_read_seq;
  logic        clk = 1'b0;
  logic        rst_n, sclk, cs_n, qe, busy;
  logic [3:0]  io_in, io_out, io_oe;
  logic [23:0] mem_addr;
  logic [7:0]  mem_data;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] memf(input logic [23:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
  endfunction
  assign mem_data = memf(mem_addr);

  qio_read_seq i_qio_read_seq (
    .clk, .rst_n, .sclk, .cs_n, .io_in, .io_out, .io_oe,
    .qe, .busy, .mem_addr, .mem_data
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$], got_q[$];
  string      tag_q[$];
  event       got_ev;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // scoreboard monitor
  initial forever begin
    @(got_ev);
    while (got_q.size() > 0) chk(tag_q.pop_front(), got_q.pop_front(), exp_q.pop_front());
  end

  // one serial clock: sample before the rise, rise, fall
  task automatic tick(input logic [3:0] v, output logic [3:0] so, output logic [3:0] soe);
    io_in = v;
    repeat (5) @(negedge clk);
    so  = io_out;
    soe = io_oe;
    sclk = 1'b1;
    repeat (5) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic frame(input bit has_op, input logic [7:0] op, input bit quad,
                       input logic [23:0] a, input logic [7:0] m, input int nb,
                       input bit expect_data, input string tag);
    logic [3:0] so, soe, want_oe;
    logic [7:0] acc;
    bit pre_bad = 0, oe_bad = 0;
    want_oe = expect_data ? (quad ? 4'hF : 4'h3) : 4'h0;
    cs_n = 1'b0;
    repeat (5) @(negedge clk);
    if (has_op)
      for (int i = 0; i < 8; i++) begin
        tick({3'b000, op[7-i]}, so, soe);
        if (soe != 0) pre_bad = 1;
      end
    if (quad) begin
      for (int i = 0; i < 6; i++) begin tick(a[23-4*i -: 4], so, soe); if (soe != 0) pre_bad = 1; end
      for (int i = 0; i < 2; i++) begin tick(m[7-4*i -: 4], so, soe); if (soe != 0) pre_bad = 1; end
      for (int i = 0; i < 4; i++) begin tick(4'h0, so, soe); if (soe != 0) pre_bad = 1; end
    end else begin
      for (int i = 0; i < 12; i++) begin tick({2'b00, a[23-2*i -: 2]}, so, soe); if (soe != 0) pre_bad = 1; end
      for (int i = 0; i < 4; i++) begin tick({2'b00, m[7-2*i -: 2]}, so, soe); if (soe != 0) pre_bad = 1; end
    end
    for (int k = 0; k < nb; k++) begin
      acc = 8'h00;
      for (int s = 0; s < (quad ? 2 : 4); s++) begin
        tick(4'h0, so, soe);
        if (soe !== want_oe) oe_bad = 1;
        acc = quad ? {acc[3:0], so} : {acc[5:0], so[1:0]};
      end
      if (expect_data) begin
        exp_q.push_back(memf(24'(a + k)));
        got_q.push_back(acc);
        tag_q.push_back({tag, " data byte"});
        -> got_ev;
      end
    end
    repeat (5) @(negedge clk);
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
    chk({tag, " R6 lines released before data"}, 32'(pre_bad), 0);
    chk({tag, " output enable during data clocks"}, 32'(oe_bad), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; io_in = 4'h0; qe = 1'b0; busy = 1'b0;
    repeat (10) @(negedge clk);
    chk("R10 lines released in reset", 32'(io_oe), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    frame(1, 8'hBB, 0, 24'h001234, 8'h00, 4, 1, "R1 dual read");
    qe = 1'b1;
    frame(1, 8'hEB, 1, 24'h0ABCDE, 8'h12, 3, 1, "R2 quad read");
    qe = 1'b0;
    frame(1, 8'hEB, 1, 24'h000040, 8'h00, 2, 0, "R3 quad without qe");
    qe = 1'b1;
    busy = 1'b1;
    frame(1, 8'hBB, 0, 24'h000050, 8'h00, 2, 0, "R4 dual while busy");
    frame(1, 8'hEB, 1, 24'h000060, 8'h00, 2, 0, "R4 quad while busy");
    busy = 1'b0;
    frame(1, 8'hBB, 0, 24'hFFFFFE, 8'h00, 4, 1, "R5 wrap");
    frame(1, 8'h0B, 0, 24'h000070, 8'h00, 2, 0, "R11 unknown opcode");

    frame(1, 8'hEB, 1, 24'h000100, 8'hA7, 2, 1, "R7 enter quad");
    frame(0, 8'h00, 1, 24'h000200, 8'hA0, 2, 1, "R7 no opcode");
    frame(0, 8'h00, 1, 24'h000300, 8'h3C, 2, 1, "R8 leaving frame");
    frame(0, 8'h00, 1, 24'h000400, 8'h00, 2, 0, "R8 opcode required");
    frame(1, 8'hEB, 1, 24'h000410, 8'h00, 1, 1, "R8 normal again");

    frame(1, 8'hBB, 0, 24'h000500, 8'hA0, 1, 1, "R9 enter dual");
    frame(0, 8'h00, 0, 24'hFFFFFF, 8'hFF, 1, 0, "R9 dual exit frame");
    frame(1, 8'hBB, 0, 24'h000600, 8'h00, 2, 1, "R9 opcode after dual exit");
    frame(1, 8'hEB, 1, 24'h000700, 8'hA0, 1, 1, "R9 enter quad");
    frame(0, 8'h00, 1, 24'hFFFFFF, 8'hFF, 1, 0, "R9 quad exit frame");
    frame(1, 8'hEB, 1, 24'h000800, 8'h00, 1, 1, "R9 opcode after quad exit");

    frame(1, 8'hBB, 0, 24'h000900, 8'hA0, 1, 1, "R10 enter");
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    chk("R10 lines released after reset", 32'(io_oe), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    frame(1, 8'hBB, 0, 24'h000A00, 8'h00, 2, 1, "R10 opcode after reset");

    repeat (20) @(negedge clk);
    -> got_ev;
    repeat (2) @(negedge clk);
    finish_up();
  end
endmodule